// File: doc/BRIEF.md
# NAND Bus Cycle Engine

This block turns one command word at a time into byte cycles on an 8-bit NAND flash bus. A command word gives a mode (write bytes, read bytes, or wait until the device reports ready), an address space for the bytes (command latch, address latch or plain data), the target chip, a byte count and two flags. One flag spreads a command string over both latches. The other keeps the chip enabled after the word ends. Write bytes come in on a valid/ready stream and read bytes go out on another, so a DMA front end or a sequencer can feed the engine directly.

Cycle timing comes from configuration inputs that give cycle counts: address setup, strobe (data setup) width, data hold, and extra read sample delay. A busy timeout bounds the wait-for-ready mode. The per-chip ready/busy lines pass through a synchronizer first. When a wait runs out, a sticky error flag is set and the word still ends with the normal done pulse.

Top module: `nand_cycle_engine`

## Requirements
- R1: After reset the engine is idle: cmd_ready is 1, every nand_ce_n bit is 1, nand_we_n and nand_re_n are 1, nand_cle, nand_ale, done and timeout_err are 0.
- R2: A write word (cmd_mode 0) of N bytes gives exactly N nand_we_n low pulses. Each pulse drives the next byte taken from wr_data, in order, with nand_dq_oe high, and nand_dq_out does not change while nand_we_n is low.
- R3: Each nand_we_n or nand_re_n low pulse lasts cfg_data_setup cycles, and a value of 0 gives 256 cycles. The two strobes are never low together.
- R4: In a write word with wr_valid held high, nand_we_n stays high for cfg_data_hold + 1 + cfg_addr_setup cycles between consecutive pulses, and a cfg_data_hold of 0 counts as 256.
- R5: Counting from the first falling clock edge after the accepting edge as cycle 0, the first strobe goes low in cycle cfg_addr_setup + 1 for a write word and in cycle cfg_addr_setup for a read word.
- R6: Latch lines during a byte follow cmd_space (0 data, 1 command latch, 2 address latch). Space 2 raises only nand_ale. Space 0 raises neither. Space 1 raises nand_cle for every byte when cmd_incr is 0. When cmd_incr is 1, space 1 raises nand_cle for byte 0 and nand_ale for all later bytes. The two latch lines are never high together.
- R7: A read word (cmd_mode 1) returns N bytes on rd_data/rd_valid in order. Each is the value on nand_dq_in at the clock edge cfg_sample_extra + 1 cycles after nand_re_n rises, even when this is later than the hold time. Backpressure on rd_ready loses no byte.
- R8: While a word runs, exactly the bit cmd_chip of nand_ce_n is low. After done it returns high unless cmd_lock_cs was 1, in which case it stays low while the engine is idle.
- R9: A wait word (cmd_mode 2) ends with done and no error once the synchronized nand_rb bit at index cmd_chip is high. Ready bits of other chips have no effect.
- R10: If the selected ready bit stays low, done appears in cycle cfg_busy_timeout + 1 and timeout_err goes to 1. timeout_err then stays 1 through later words until reset.
- R11: A write or read word with cmd_count 0 makes no strobe and gives done in cycle 0.
- R12: cmd_ready is 0 from the accepting edge until the engine is idle again, and done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine idle, word accepted when valid |
| cmd_mode | input | 2 | 0 write, 1 read, 2 wait for ready |
| cmd_space | input | 2 | 0 data, 1 command latch, 2 address latch |
| cmd_incr | input | 1 | Command latch first byte only, address latch after |
| cmd_lock_cs | input | 1 | Keep chip enable low after the word |
| cmd_chip | input | CS_W | Target chip number |
| cmd_count | input | CNT_W | Byte count |
| cfg_addr_setup | input | 8 | Latch setup cycles before a strobe |
| cfg_data_setup | input | 8 | Strobe low cycles, 0 means 256 |
| cfg_data_hold | input | 8 | Strobe high cycles after a byte, 0 means 256 |
| cfg_sample_extra | input | 3 | Read sample delay after strobe release |
| cfg_busy_timeout | input | TO_W | Wait-for-ready limit in cycles |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte taken |
| nand_dq_out | output | 8 | Bus data driven out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from the device |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | NCHIP | Chip enables, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | NCHIP | Ready/busy per chip, 1 is ready |
| done | output | 1 | Word finished pulse |
| timeout_err | output | 1 | Sticky wait timeout flag |

## Verification
The hardest cases to reach from the ports are a read sample point that falls after the hold phase ends, and a stalled read consumer during a multi-byte read. The bench device model puts a tag on nand_dq_in that changes every cycle after nand_re_n rises, so the captured byte shows exactly which edge sampled it. Random words combine sample delays larger than the hold count with a rd_ready that toggles at random. Directed words set the strobe and hold fields to zero to reach the 256-cycle limit, and raise only a wrong chip's ready line so that the timeout must fire.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WAIT  = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SPACE_DATA = 2'd0,
    SPACE_CMD  = 2'd1,
    SPACE_ADDR = 2'd2,
    SPACE_RSVD = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_ASET,
    S_STROBE,
    S_HOLD,
    S_WAIT,
    S_DONE
  } state_e;

  // zero in a strobe or hold field stands for the longest span
  function automatic logic [8:0] span_of(input logic [7:0] f);
    return (f == 8'd0) ? 9'd256 : {1'b0, f};
  endfunction

endpackage

// File: rtl/nand_eng_sync.sv
module nand_eng_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nand_eng_tick.sv
module nand_eng_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_eng_pkg::*;
#(
  parameter int NCHIP       = 4,
  parameter int CNT_W       = 12,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CS_W       = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_mode,
  input  logic [1:0]       cmd_space,
  input  logic             cmd_incr,
  input  logic             cmd_lock_cs,
  input  logic [CS_W-1:0]  cmd_chip,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [7:0]       cfg_addr_setup,
  input  logic [7:0]       cfg_data_setup,
  input  logic [7:0]       cfg_data_hold,
  input  logic [2:0]       cfg_sample_extra,
  input  logic [TO_W-1:0]  cfg_busy_timeout,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic [NCHIP-1:0] nand_ce_n,
  output logic             nand_we_n,
  output logic             nand_re_n,
  input  logic [NCHIP-1:0] nand_rb,
  output logic             done,
  output logic             timeout_err
);

  state_e           st, st_nx;
  mode_e            c_mode;
  space_e           c_space;
  logic             c_incr, c_lock;
  logic [CS_W-1:0]  c_chip;
  logic [CNT_W-1:0] c_count;
  logic [7:0]       dq_q, rd_q;
  logic             rd_vld, captured, err_q;
  logic             ce_act;
  logic [CS_W-1:0]  ce_chip;
  logic [NCHIP-1:0] rb_s;
  logic [TO_W-1:0]  ph_cnt;
  logic [CNT_W-1:0] idx;

  logic             accept, is_wr, in_bus, hold_done, is_last, sel_rdy;
  logic             do_capture, wait_expire;
  logic [TO_W-1:0]  a_last, s_last, h_last;

  // ready/busy lines cross into the engine clock
  nand_eng_sync #(.WIDTH(NCHIP), .STAGES(SYNC_STAGES)) u_rb_sync (
    .clk(clk), .rst(rst), .d(nand_rb), .q(rb_s)
  );

  // cycles spent in the present state
  nand_eng_tick #(.W(TO_W)) u_phase (
    .clk(clk), .rst(rst), .clr(st_nx != st), .en(1'b1), .cnt(ph_cnt)
  );

  // bytes finished in the present word
  nand_eng_tick #(.W(CNT_W)) u_bytes (
    .clk(clk), .rst(rst), .clr(accept), .en(hold_done), .cnt(idx)
  );

  assign accept    = (st == S_IDLE) && cmd_valid;
  assign is_wr     = (c_mode == MODE_WRITE);
  assign in_bus    = (st == S_ASET) || (st == S_STROBE) || (st == S_HOLD);
  assign a_last    = TO_W'(cfg_addr_setup) - TO_W'(1);
  assign s_last    = TO_W'(span_of(cfg_data_setup)) - TO_W'(1);
  assign h_last    = TO_W'(span_of(cfg_data_hold)) - TO_W'(1);
  assign is_last   = (idx == c_count - CNT_W'(1));
  assign sel_rdy   = rb_s[c_chip];
  assign hold_done = (st == S_HOLD) && (ph_cnt >= h_last) &&
                     (is_wr || captured) && !rd_vld;
  assign do_capture  = (st == S_HOLD) && !is_wr && !captured &&
                       (ph_cnt == TO_W'(cfg_sample_extra));
  assign wait_expire = (st == S_WAIT) && !sel_rdy && (ph_cnt == cfg_busy_timeout);

  // first bus state of a byte: writes fetch data, setup phase only if nonzero
  function automatic state_e byte_entry(input mode_e m, input logic [7:0] a);
    if (m == MODE_WRITE)  return S_FETCH;
    else if (a == 8'd0)   return S_STROBE;
    else                  return S_ASET;
  endfunction

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (cmd_valid) begin
        if (mode_e'(cmd_mode) == MODE_WAIT)  st_nx = S_WAIT;
        else if (cmd_count == '0)            st_nx = S_DONE;
        else st_nx = byte_entry(mode_e'(cmd_mode), cfg_addr_setup);
      end
      S_FETCH:  if (wr_valid) st_nx = (cfg_addr_setup == 8'd0) ? S_STROBE : S_ASET;
      S_ASET:   if (ph_cnt == a_last) st_nx = S_STROBE;
      S_STROBE: if (ph_cnt == s_last) st_nx = S_HOLD;
      S_HOLD:   if (hold_done) st_nx = is_last ? S_DONE : byte_entry(c_mode, cfg_addr_setup);
      S_WAIT:   if (sel_rdy || wait_expire) st_nx = S_DONE;
      S_DONE:   st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      c_mode   <= MODE_WRITE;
      c_space  <= SPACE_DATA;
      c_incr   <= 1'b0;
      c_lock   <= 1'b0;
      c_chip   <= '0;
      c_count  <= '0;
      dq_q     <= '0;
      rd_q     <= '0;
      rd_vld   <= 1'b0;
      captured <= 1'b0;
      err_q    <= 1'b0;
      ce_act   <= 1'b0;
      ce_chip  <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        c_mode  <= mode_e'(cmd_mode);
        c_space <= space_e'(cmd_space);
        c_incr  <= cmd_incr;
        c_lock  <= cmd_lock_cs;
        c_chip  <= cmd_chip;
        c_count <= cmd_count;
        ce_act  <= 1'b1;
        ce_chip <= cmd_chip;
      end
      if (st == S_DONE) ce_act <= c_lock;
      if ((st == S_FETCH) && wr_valid) dq_q <= wr_data;
      if (st == S_STROBE) captured <= 1'b0;
      else if (do_capture) captured <= 1'b1;
      if (do_capture) begin
        rd_q   <= nand_dq_in;
        rd_vld <= 1'b1;
      end else if (rd_ready) begin
        rd_vld <= 1'b0;
      end
      if (wait_expire) err_q <= 1'b1;
    end
  end

  // bus pins decode registered state only
  assign cmd_ready   = (st == S_IDLE);
  assign wr_ready    = (st == S_FETCH);
  assign done        = (st == S_DONE);
  assign timeout_err = err_q;
  assign rd_data     = rd_q;
  assign rd_valid    = rd_vld;
  assign nand_dq_out = dq_q;
  assign nand_dq_oe  = in_bus && is_wr;
  assign nand_we_n   = !((st == S_STROBE) && is_wr);
  assign nand_re_n   = !((st == S_STROBE) && !is_wr);
  assign nand_cle    = in_bus && (c_space == SPACE_CMD) && ((idx == '0) || !c_incr);
  assign nand_ale    = in_bus && ((c_space == SPACE_ADDR) ||
                                  ((c_space == SPACE_CMD) && c_incr && (idx != '0)));
  assign nand_ce_n   = ce_act ? ~(NCHIP'(1) << ce_chip) : {NCHIP{1'b1}};

endmodule

// File: rtl/nand_cycle_engine_chk.sv
module nand_cycle_engine_chk #(
  parameter int NCHIP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [7:0]       nand_dq_out,
  input logic             nand_dq_oe,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic [NCHIP-1:0] nand_ce_n,
  input logic             nand_we_n,
  input logic             nand_re_n,
  input logic             done,
  input logic             timeout_err
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (nand_we_n || nand_re_n));

  p_latch_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  p_strobe_ce_r8: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> ($countones(~nand_ce_n) == 1));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_accept_busy_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err);

  p_dq_steady_r2: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

  p_oe_write_r2: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_dq_oe);
endmodule

bind nand_cycle_engine nand_cycle_engine_chk #(.NCHIP(NCHIP)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .done(done), .timeout_err(timeout_err)
);

// File: tb/nand_cycle_engine_test.sv
module nand_cycle_engine_test;
  localparam int NCHIP = 4;
  localparam int CNT_W = 12;
  localparam int TO_W  = 16;
  localparam int CS_W  = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_mode = 0, cmd_space = 0;
  logic cmd_incr = 0, cmd_lock_cs = 0;
  logic [CS_W-1:0] cmd_chip = 0;
  logic [CNT_W-1:0] cmd_count = 0;
  logic [7:0] cfg_addr_setup = 1, cfg_data_setup = 1, cfg_data_hold = 1;
  logic [2:0] cfg_sample_extra = 0;
  logic [TO_W-1:0] cfg_busy_timeout = 16'h0500;
  logic [7:0] wr_data;
  logic wr_valid = 1'b1, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 1'b0;
  logic [7:0] nand_dq_out, nand_dq_in = 0;
  logic nand_dq_oe, nand_cle, nand_ale, nand_we_n, nand_re_n, done, timeout_err;
  logic [NCHIP-1:0] nand_ce_n, nand_rb = 0;

  nand_cycle_engine #(.NCHIP(NCHIP), .CNT_W(CNT_W), .TO_W(TO_W)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, wd = 0;
  logic [7:0] wbuf [16];
  int wptr = 0;
  logic [7:0] rbuf [16];
  int nrd = 0;
  logic rd_rand = 1'b0;

  // write byte source and read byte sink, updated at the active edge
  assign wr_data = wbuf[wptr[3:0]];
  always @(posedge clk) begin
    if (wr_valid && wr_ready) wptr <= wptr + 1;
    if (rd_valid && rd_ready) begin
      rbuf[nrd[3:0]] <= rd_data;
      nrd <= nrd + 1;
    end
    rd_ready <= rd_rand ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // bus monitor for write strobes and device model for reads
  int nwb = 0, lo_run = 0, hi_run = 0, ce_bad = 0, rlatch_bad = 0;
  int lo_w [16], gap_w [16];
  logic [7:0] dat_w [16];
  logic cle_w [16], ale_w [16];
  logic [7:0] cur_dq;
  logic cur_cle, cur_ale, prev_we = 1'b1, prev_re = 1'b1;
  logic [NCHIP-1:0] exp_ce = '1;
  int ridx = 0, rk = 0;
  logic [3:0] rbyte = 0;

  always @(negedge clk) begin
    if (!nand_we_n || !nand_re_n) if (nand_ce_n !== exp_ce) ce_bad++;
    if (!nand_we_n) begin
      if (prev_we) begin gap_w[nwb[3:0]] = hi_run; lo_run = 0; end
      lo_run++;
      cur_dq = nand_dq_out; cur_cle = nand_cle; cur_ale = nand_ale;
    end else begin
      if (!prev_we) begin
        dat_w[nwb[3:0]] = cur_dq; cle_w[nwb[3:0]] = cur_cle; ale_w[nwb[3:0]] = cur_ale;
        lo_w[nwb[3:0]] = lo_run; nwb++; hi_run = 0;
      end
      hi_run++;
    end
    prev_we = nand_we_n;
    if (!nand_re_n) begin
      if (nand_cle || nand_ale) rlatch_bad++;
      nand_dq_in = {ridx[3:0], 4'hF};
    end else if (!prev_re) begin
      rbyte = ridx[3:0]; ridx++; rk = 0;
      nand_dq_in = {rbyte, 4'(rk)};
    end else begin
      if (rk < 14) rk++;
      nand_dq_in = {rbyte, 4'(rk)};
    end
    prev_re = nand_re_n;
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 190000);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_cle(input int sp, input bit inc, input int i);
    return (sp == 1) && (i == 0 || !inc);
  endfunction
  function automatic bit exp_ale(input int sp, input bit inc, input int i);
    return (sp == 2) || (sp == 1 && inc && i != 0);
  endfunction
  function automatic int spanv(input int f);
    return (f == 0) ? 256 : f;
  endfunction

  int lat, first_strobe, busy_seen;

  // issue one word while idle and follow it until done
  task automatic run_cmd(input int m, input int sp, input bit inc, input bit lk,
                         input int chip, input int cnt);
    @(negedge clk);
    nwb = 0; wptr = 0; nrd = 0; ridx = 0; ce_bad = 0; rlatch_bad = 0;
    exp_ce = ~(NCHIP'(1) << chip);
    cmd_mode = 2'(m); cmd_space = 2'(sp); cmd_incr = inc; cmd_lock_cs = lk;
    cmd_chip = CS_W'(chip); cmd_count = CNT_W'(cnt); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0; first_strobe = -1;
    busy_seen = cmd_ready ? 0 : 1;
    while (!done && lat < 100000) begin
      if (first_strobe < 0 && (!nand_we_n || !nand_re_n)) first_strobe = lat;
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    chk(!done, "R12 done pulse width", done, 0);
  endtask

  task automatic fill_wbuf();
    for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
  endtask

  task automatic check_write(input int sp, input bit inc, input int cnt, input string tag);
    int bad_d = 0, bad_l = 0, bad_w = 0, bad_g = 0;
    chk(nwb == cnt, {tag, " R2 byte count"}, nwb, cnt);
    for (int i = 0; i < cnt && i < 16; i++) begin
      if (dat_w[i] !== wbuf[i]) bad_d++;
      if (cle_w[i] !== exp_cle(sp, inc, i) || ale_w[i] !== exp_ale(sp, inc, i)) bad_l++;
      if (lo_w[i] != spanv(int'(cfg_data_setup))) bad_w++;
      if (i > 0 && gap_w[i] != spanv(int'(cfg_data_hold)) + 1 + int'(cfg_addr_setup)) bad_g++;
    end
    chk(bad_d == 0, {tag, " R2 write data"}, bad_d, 0);
    chk(bad_l == 0, {tag, " R6 latch lines"}, bad_l, 0);
    chk(bad_w == 0, {tag, " R3 strobe width"}, bad_w, 0);
    chk(bad_g == 0, {tag, " R4 hold gap"}, bad_g, 0);
    chk(first_strobe == int'(cfg_addr_setup) + 1, {tag, " R5 write setup"},
        first_strobe, int'(cfg_addr_setup) + 1);
    chk(ce_bad == 0, {tag, " R8 chip enable"}, ce_bad, 0);
  endtask

  task automatic check_read(input int cnt, input string tag);
    int bad = 0;
    chk(nrd == cnt, {tag, " R7 read count"}, nrd, cnt);
    for (int i = 0; i < cnt && i < 16; i++)
      if (rbuf[i] !== {4'(i), 1'b0, cfg_sample_extra}) bad++;
    chk(bad == 0, {tag, " R7 read sample point"}, bad, 0);
    chk(first_strobe == int'(cfg_addr_setup), {tag, " R5 read setup"},
        first_strobe, int'(cfg_addr_setup));
    chk(rlatch_bad == 0, {tag, " R6 data space latches"}, rlatch_bad, 0);
    chk(ce_bad == 0, {tag, " R8 chip enable"}, ce_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    fill_wbuf();
    repeat (5) @(negedge clk);
    chk(cmd_ready && nand_ce_n == '1 && nand_we_n && nand_re_n && !nand_cle && !nand_ale
        && !done && !timeout_err, "R1 reset state", {nand_ce_n, cmd_ready}, 5'h1f);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready && nand_ce_n == '1, "R1 idle after reset", cmd_ready, 1);

    // command string: first byte command latch, rest address latch
    cfg_addr_setup = 2; cfg_data_setup = 3; cfg_data_hold = 2;
    fill_wbuf();
    run_cmd(0, 1, 1'b1, 1'b0, 1, 5);
    check_write(1, 1'b1, 5, "cmdstr");
    chk(busy_seen == 1, "R12 busy after accept", busy_seen, 1);
    chk(nand_ce_n == '1, "R8 released without lock", nand_ce_n, 15);

    // zero fields select the longest strobe and hold
    cfg_addr_setup = 0; cfg_data_setup = 0; cfg_data_hold = 0;
    fill_wbuf();
    run_cmd(0, 1, 1'b0, 1'b0, 0, 3);
    check_write(1, 1'b0, 3, "zerofld");

    // address space with chip select lock
    cfg_addr_setup = 1; cfg_data_setup = 2; cfg_data_hold = 1;
    fill_wbuf();
    run_cmd(0, 2, 1'b0, 1'b1, 2, 4);
    check_write(2, 1'b0, 4, "addrlock");
    repeat (3) @(negedge clk);
    chk(nand_ce_n == 4'b1011, "R8 held by lock", nand_ce_n, 11);

    // read with sample point inside the hold time
    cfg_addr_setup = 1; cfg_data_setup = 2; cfg_data_hold = 4; cfg_sample_extra = 2;
    rd_rand = 1'b1;
    run_cmd(1, 0, 1'b0, 1'b0, 3, 6);
    check_read(6, "rdin");
    chk(nand_ce_n == '1, "R8 released after read", nand_ce_n, 15);

    // read with sample point past the hold time
    cfg_addr_setup = 0; cfg_data_hold = 1; cfg_sample_extra = 6;
    run_cmd(1, 0, 1'b0, 1'b0, 0, 4);
    check_read(4, "rdlate");

    // zero length word
    run_cmd(0, 0, 1'b0, 1'b0, 1, 0);
    chk(lat == 0 && nwb == 0, "R11 empty word", lat * 100 + nwb, 0);

    // wait with the selected chip ready
    cfg_busy_timeout = 40;
    nand_rb = 4'b0010;
    repeat (4) @(negedge clk);
    run_cmd(2, 0, 1'b0, 1'b0, 1, 0);
    chk(lat == 1 && !timeout_err, "R9 ready ends wait", lat, 1);

    // wait where only other chips are ready
    cfg_busy_timeout = 20;
    nand_rb = 4'b1110;
    run_cmd(2, 0, 1'b0, 1'b0, 0, 0);
    chk(lat == 21, "R10 timeout cycle", lat, 21);
    chk(timeout_err, "R10 error raised", timeout_err, 1);
    chk(lat > 1, "R9 other chips ignored", lat, 21);

    // error stays through a later good word
    nand_rb = 4'b0001;
    repeat (4) @(negedge clk);
    run_cmd(2, 0, 1'b0, 1'b0, 0, 0);
    chk(lat == 1 && timeout_err, "R10 sticky error", timeout_err, 1);

    // constrained random words
    for (int it = 0; it < 24; it++) begin
      int m, sp, cnt, ch;
      bit inc;
      m  = $urandom_range(0, 1);
      sp = (m == 1) ? 0 : $urandom_range(0, 2);
      inc = 1'($urandom_range(0, 1));
      cnt = $urandom_range(1, 6);
      ch  = $urandom_range(0, 3);
      cfg_addr_setup = 8'($urandom_range(0, 3));
      cfg_data_setup = 8'($urandom_range(1, 4));
      cfg_data_hold  = 8'($urandom_range(1, 4));
      cfg_sample_extra = 3'($urandom_range(0, 7));
      fill_wbuf();
      run_cmd(m, sp, inc, 1'b0, ch, cnt);
      if (m == 0) check_write(sp, inc, cnt, "rand");
      else        check_read(cnt, "rand");
    end

    finish_run();
  end
endmodule